// File: doc/BRIEF.md
# Quadrature Position Counter with Dual Compare

This block keeps a position count from a two-phase incremental encoder. Two phase inputs (A and B) decide when to step the counter and in which direction; a third input (Z, the index) can reset the count. All three pins come from outside the clock domain, so each one passes through a synchroniser before any decision is taken. Configuration arrives as plain inputs: an enable, a preload word with a hold control, two compare words, a decode-mode select, per-compare clear enables and the clear-source settings. The block drives a single-cycle interrupt pulse for each compare.

Software sets the preload and compare words and then raises the enable. That loads the counter and copies the compare words into internal buffers. The first encoder step after that only arms the counter. Each later step moves the count by one, wrapping at the ends of the range. When a step lands on a buffered compare value, the matching pulse fires. The counter can return to zero in three ways: after a match on a compare whose clear enable is set, on a selected edge of the index pin, or while A, B and Z sit at a programmed level pattern. Any of these clears also reloads the compare buffers.

Top module: `qenc_cmp_counter`

## Requirements
- R1: After reset, `count` is 0 and `match_irq` is all zero.
- R2: In the cycle after `enable` rises, `count` holds `preload_val` when `preload_hold` is 0. When `preload_hold` is 1, `count` keeps its previous value.
- R3: After each rise of `enable`, the first step event of the selected decode mode arms the counter and leaves `count` unchanged. Only later events change it.
- R4: With `dir_mode` = 2'b10, every single-pin change of A or B is a step. Taking {A,B}, the order 00→10→11→01→00 counts up by one and the reverse order counts down. With `dir_mode` = 2'b11, both directions are swapped.
- R5: With `dir_mode` = 2'b00, only a rising edge of A is a step. It counts up when B is 0 and down when B is 1. Edges of B and falling edges of A are ignored.
- R6: With `dir_mode` = 2'b01, both edges of A are steps, counting up when A differs from B after the edge. Edges of B are ignored.
- R7: The count wraps modulo 2^CNT_W in both directions (0xFFFF+1 = 0, 0−1 = 0xFFFF).
- R8: A pin change that steps the counter shows its new count three cycles later. If that new count equals buffered compare i, `match_irq[i]` is high for exactly that one cycle.
- R9: If `cmp_clr_en[i]` is 1, a match on compare i clears `count` to 0 in the following cycle.
- R10: With `clr_src_sel` = 0, an index edge clears the count three cycles after the pin change. `clr_edge_sel` chooses the edge: 00 none, 01 rising, 10 falling, 11 both.
- R11: With `clr_src_sel` = 1, `count` is 0 whenever the synchronised {A,B,Z} equals `clr_level` (bit 2 = A, bit 1 = B, bit 0 = Z). This clear wins over a step in the same cycle.
- R12: The compare buffers take `cmp_val` only when `enable` rises or the counter is cleared. A change of `cmp_val` at any other time does not alter which count raises a match.
- R13: While `enable` is 0, `count` holds, `match_irq` stays 0 and encoder pin changes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter run enable; its rising edge loads preload and compare buffers |
| preload_hold | input | 1 | 1 keeps the current count when enable rises |
| preload_val | input | CNT_W | Value loaded into the counter when enable rises |
| cmp_val | input | NUM_CMP*CNT_W | Compare words, compare i at bits [i*CNT_W +: CNT_W] |
| dir_mode | input | 2 | Decode mode: 00 x1, 01 x2, 10 x4, 11 x4 reversed |
| cmp_clr_en | input | NUM_CMP | Per-compare clear-on-match enable |
| clr_src_sel | input | 1 | 0 index-edge clear, 1 level-pattern clear |
| clr_edge_sel | input | 2 | Index edge: 00 none, 01 rise, 10 fall, 11 both |
| clr_level | input | 3 | Level pattern {A,B,Z} for the pattern clear |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_z | input | 1 | Encoder index / clear pin (asynchronous) |
| count | output | CNT_W | Current position count |
| match_irq | output | NUM_CMP | One-cycle compare match pulses |

## Verification
A pin change applied between clock edges reaches `count` and `match_irq` on the third rising edge after it, two for the synchroniser and one for the count register. A clear after a compare match lands one edge later than the match, while a rise of `enable` acts on the next edge. The driver records, for each stimulus, the cycle in which each of these results is due, and queues the expected count and pulse vector under that cycle number. A monitor samples on the falling edge and compares each queued item in exactly its due cycle. It also checks the cycle after every step, so a pulse that lasts too long or a missing clear-on-match is caught in the cycle where it would show.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

  typedef enum logic [1:0] {
    DEC_X1     = 2'b00,
    DEC_X2     = 2'b01,
    DEC_X4     = 2'b10,
    DEC_X4_REV = 2'b11
  } dec_mode_e;

  typedef enum logic [1:0] {
    ZCLR_OFF  = 2'b00,
    ZCLR_RISE = 2'b01,
    ZCLR_FALL = 2'b10,
    ZCLR_ANY  = 2'b11
  } zclr_edge_e;

  typedef struct packed {
    logic go;
    logic up;
  } step_t;

  // Turns one pair of synchronised samples into a step request.
  function automatic step_t decode_step(input dec_mode_e mode,
                                        input logic a_now, input logic a_old,
                                        input logic b_now, input logic b_old);
    step_t s;
    logic a_chg;
    logic b_chg;
    logic fwd;
    a_chg = a_now ^ a_old;
    b_chg = b_now ^ b_old;
    s.go  = 1'b0;
    s.up  = 1'b0;
    fwd   = a_chg ? (a_now ^ b_now) : ~(a_now ^ b_now);
    if (!(a_chg && b_chg)) begin
      case (mode)
        DEC_X1: begin
          s.go = a_chg & a_now;
          s.up = ~b_now;
        end
        DEC_X2: begin
          s.go = a_chg;
          s.up = a_now ^ b_now;
        end
        DEC_X4: begin
          s.go = a_chg | b_chg;
          s.up = fwd;
        end
        default: begin
          s.go = a_chg | b_chg;
          s.up = ~fwd;
        end
      endcase
    end
    return s;
  endfunction

  // Index edge qualifier.
  function automatic logic z_edge_hit(input zclr_edge_e sel,
                                      input logic now, input logic old);
    logic hit;
    case (sel)
      ZCLR_RISE: hit = now & ~old;
      ZCLR_FALL: hit = ~now & old;
      ZCLR_ANY:  hit = now ^ old;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
`timescale 1ns/1ps
module qenc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_now,
  output logic [WIDTH-1:0] pin_old
);
  localparam int TAPS = STAGES + 1;

  logic [WIDTH-1:0] chain [TAPS];

  generate
    for (genvar s = 0; s < TAPS; s++) begin : g_tap
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_now = chain[STAGES-1];
  assign pin_old = chain[STAGES];
endmodule

// File: rtl/qenc_clear_sel.sv
`timescale 1ns/1ps
module qenc_clear_sel
  import qenc_pkg::*;
(
  input  logic       src_level,
  input  logic [1:0] edge_sel,
  input  logic [2:0] level_pat,
  input  logic [2:0] pins_now,
  input  logic       z_old,
  output logic       clr_req
);
  localparam int ZB = 0;

  logic edge_clr;
  logic level_clr;

  assign edge_clr  = z_edge_hit(zclr_edge_e'(edge_sel), pins_now[ZB], z_old);
  assign level_clr = (pins_now == level_pat);
  assign clr_req   = src_level ? level_clr : edge_clr;
endmodule

// File: rtl/qenc_cmp_bank.sv
`timescale 1ns/1ps
module qenc_cmp_bank #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reload,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0]         count,
  input  logic                     qualify,
  output logic [NUM_CMP-1:0]       hit
);
  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      logic [CNT_W-1:0] shadow;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shadow <= '0;
        else if (reload) shadow <= cmp_val[i*CNT_W +: CNT_W];
      end
      assign hit[i] = qualify && (count == shadow);
    end
  endgenerate
endmodule

// File: rtl/qenc_cmp_counter.sv
`timescale 1ns/1ps
module qenc_cmp_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CMP     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     preload_hold,
  input  logic [CNT_W-1:0]         preload_val,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_val,
  input  logic [1:0]               dir_mode,
  input  logic [NUM_CMP-1:0]       cmp_clr_en,
  input  logic                     clr_src_sel,
  input  logic [1:0]               clr_edge_sel,
  input  logic [2:0]               clr_level,
  input  logic                     enc_a,
  input  logic                     enc_b,
  input  logic                     enc_z,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_CMP-1:0]       match_irq
);
  localparam int PIN_N = 3;
  localparam int PIN_A = 2;
  localparam int PIN_B = 1;
  localparam int PIN_Z = 0;

  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] v,
                                                  input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  logic [PIN_N-1:0] pin_now;
  logic [PIN_N-1:0] pin_old;
  step_t            step;
  logic             clr_req;
  logic [NUM_CMP-1:0] cmp_hit;

  logic             en_q;
  logic             started;
  logic             fresh;
  logic [CNT_W-1:0] count_q;

  // Named internal events
  logic en_rise;
  logic live;
  logic arm_go;
  logic cnt_go;
  logic cnt_up;
  logic cmp_clr;
  logic clr_any;
  logic buf_reload;

  qenc_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in ({enc_a, enc_b, enc_z}),
    .pin_now(pin_now),
    .pin_old(pin_old)
  );

  assign step = decode_step(dec_mode_e'(dir_mode),
                            pin_now[PIN_A], pin_old[PIN_A],
                            pin_now[PIN_B], pin_old[PIN_B]);

  qenc_clear_sel u_clr (
    .src_level(clr_src_sel),
    .edge_sel (clr_edge_sel),
    .level_pat(clr_level),
    .pins_now (pin_now),
    .z_old    (pin_old[PIN_Z]),
    .clr_req  (clr_req)
  );

  qenc_cmp_bank #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (buf_reload),
    .cmp_val(cmp_val),
    .count  (count_q),
    .qualify(enable & fresh),
    .hit    (cmp_hit)
  );

  assign en_rise    = enable & ~en_q;
  assign live       = enable & ~en_rise;
  assign arm_go     = live & step.go & ~started;
  assign cnt_go     = live & step.go & started;
  assign cnt_up     = step.up;
  assign cmp_clr    = |(cmp_hit & cmp_clr_en);
  assign clr_any    = live & (clr_req | cmp_clr);
  assign buf_reload = en_rise | clr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      started <= 1'b0;
      fresh   <= 1'b0;
      count_q <= '0;
    end else begin
      en_q  <= enable;
      fresh <= cnt_go & ~clr_any;
      if (!enable || en_rise) started <= 1'b0;
      else if (arm_go)        started <= 1'b1;
      if (en_rise) begin
        if (!preload_hold) count_q <= preload_val;
      end else if (clr_any) begin
        count_q <= '0;
      end else if (cnt_go) begin
        count_q <= step_value(count_q, cnt_up);
      end
    end
  end

  assign count     = count_q;
  assign match_irq = cmp_hit;
endmodule

// File: rtl/qenc_cmp_checker.sv
`timescale 1ns/1ps
module qenc_cmp_checker #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               preload_hold,
  input logic [CNT_W-1:0]   preload_val,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_CMP-1:0] match_irq,
  input logic               en_rise,
  input logic               arm_go,
  input logic               cnt_go,
  input logic               cnt_up,
  input logic               clr_any
);
  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise && !preload_hold |=> count == $past(preload_val)); // R2
  AST_PRELOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise && preload_hold |=> $stable(count)); // R2
  AST_ARM_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_go |=> $stable(count)); // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_go && !clr_any |=> count == ($past(cnt_up) ? CNT_W'($past(count) + 1'b1)
                                                   : CNT_W'($past(count) - 1'b1))); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> count == '0); // R11
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count)); // R13
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> match_irq == '0); // R13

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_pulse
      AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq[i] |=> !match_irq[i]); // R8
    end
  endgenerate
endmodule

bind qenc_cmp_counter qenc_cmp_checker #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .preload_hold(preload_hold),
  .preload_val (preload_val),
  .count       (count),
  .match_irq   (match_irq),
  .en_rise     (en_rise),
  .arm_go      (arm_go),
  .cnt_go      (cnt_go),
  .cnt_up      (cnt_up),
  .clr_any     (clr_any)
);

// File: tb/tb_qenc_cmp_counter.sv
`timescale 1ns/1ps
module tb_qenc_cmp_counter;
  localparam int CW = 16;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          preload_hold = 1'b0;
  logic [CW-1:0] preload_val = '0;
  logic [NC*CW-1:0] cmp_val = '0;
  logic [1:0]    dir_mode = 2'b10;
  logic [NC-1:0] cmp_clr_en = '0;
  logic          clr_src_sel = 1'b0;
  logic [1:0]    clr_edge_sel = 2'b00;
  logic [2:0]    clr_level = 3'b111;
  logic          enc_a = 1'b0;
  logic          enc_b = 1'b0;
  logic          enc_z = 1'b0;
  logic [CW-1:0] count;
  logic [NC-1:0] match_irq;

  qenc_cmp_counter #(.CNT_W(CW), .NUM_CMP(NC)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .preload_hold(preload_hold),
    .preload_val(preload_val), .cmp_val(cmp_val), .dir_mode(dir_mode),
    .cmp_clr_en(cmp_clr_en), .clr_src_sel(clr_src_sel), .clr_edge_sel(clr_edge_sel),
    .clr_level(clr_level), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .count(count), .match_irq(match_irq)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int            due;
    logic [CW-1:0] cnt;
    logic [NC-1:0] irq;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // Reference state
  logic [CW-1:0] m_cnt = '0;
  bit            m_started = 1'b0;
  logic [CW-1:0] m_buf [NC];
  logic          m_a = 1'b0, m_b = 1'b0, m_z = 1'b0;

  function automatic int qpos(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic push(input int due, input logic [CW-1:0] c,
                      input logic [NC-1:0] q, input string tag);
    exp_t e;
    e.due = due; e.cnt = c; e.irq = q; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic reload_model();
    for (int i = 0; i < NC; i++) m_buf[i] = cmp_val[i*CW +: CW];
  endtask

  // Monitor: compares each expected item in its due cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (e.due != cyc) begin
          failures++;
          $display("FAIL %s missed due cycle %0d (now %0d)", e.tag, e.due, cyc);
        end else if (count !== e.cnt || match_irq !== e.irq) begin
          failures++;
          $display("FAIL %s cycle %0d: count=%h irq=%b expected count=%h irq=%b",
                   e.tag, cyc, count, match_irq, e.cnt, e.irq);
        end
      end
    end
  end

  task automatic en_on(input logic hold, input string tag);
    int k;
    @(negedge clk);
    preload_hold = hold;
    enable = 1'b1;
    k = cyc;
    if (!hold) m_cnt = preload_val;
    m_started = 1'b0;
    reload_model();
    push(k + 1, m_cnt, '0, tag);
    repeat (2) @(posedge clk);
  endtask

  task automatic en_off(input string tag);
    int k;
    @(negedge clk);
    enable = 1'b0;
    k = cyc;
    push(k + 1, m_cnt, '0, tag);
    repeat (2) @(posedge clk);
  endtask

  task automatic move(input logic na, input logic nb, input string tag);
    int k, st, d;
    bit ev, clr, mclr;
    logic [NC-1:0] q;
    @(negedge clk);
    enc_a = na; enc_b = nb;
    k = cyc;
    st = (qpos(na, nb) - qpos(m_a, m_b) + 4) % 4;
    ev = 1'b0; d = 0;
    case (dir_mode)
      2'b10: begin ev = 1'b1; d = (st == 1) ? 1 : -1; end
      2'b11: begin ev = 1'b1; d = (st == 1) ? -1 : 1; end
      2'b01: begin ev = (na != m_a); d = (st == 1) ? 1 : -1; end
      default: begin ev = (na && !m_a); d = (st == 1) ? 1 : -1; end
    endcase
    m_a = na; m_b = nb;
    clr = clr_src_sel && ({na, nb, m_z} == clr_level);
    if (!enable) begin ev = 1'b0; clr = 1'b0; end
    q = '0; mclr = 1'b0;
    if (clr) begin
      m_cnt = '0;
      reload_model();
    end else if (ev) begin
      if (!m_started) m_started = 1'b1;
      else begin
        m_cnt = m_cnt + CW'(d);
        for (int i = 0; i < NC; i++) q[i] = (m_cnt == m_buf[i]);
        mclr = |(q & cmp_clr_en);
      end
    end
    push(k + 3, m_cnt, q, tag);
    if (mclr) begin
      m_cnt = '0;
      reload_model();
    end
    push(k + 4, m_cnt, '0, tag);
    repeat (4) @(posedge clk);
  endtask

  task automatic set_z(input logic nz, input string tag);
    int k;
    bit clr;
    @(negedge clk);
    enc_z = nz;
    k = cyc;
    if (clr_src_sel) clr = ({m_a, m_b, nz} == clr_level);
    else case (clr_edge_sel)
      2'b01: clr = nz && !m_z;
      2'b10: clr = !nz && m_z;
      2'b11: clr = nz != m_z;
      default: clr = 1'b0;
    endcase
    m_z = nz;
    if (!enable) clr = 1'b0;
    if (clr) begin
      m_cnt = '0;
      reload_model();
    end
    push(k + 3, m_cnt, '0, tag);
    repeat (4) @(posedge clk);
  endtask

  task automatic wait_drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) m_buf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push(cyc + 1, '0, '0, "R1 reset state");
    repeat (2) @(posedge clk);

    preload_val  = 16'hFFFE;
    cmp_val      = {16'h0003, 16'h0001};
    cmp_clr_en   = 2'b10;
    clr_edge_sel = 2'b01;
    dir_mode     = 2'b10;
    en_on(1'b0, "R2 preload on enable rise");

    move(1, 0, "R3 first edge arms only");
    move(1, 1, "R4 x4 up step");
    move(0, 1, "R7 wrap up to zero");
    move(0, 0, "R8 compare 0 pulse");
    move(1, 0, "R4 x4 up step");
    move(1, 1, "R9 compare 1 pulse then clear");
    move(1, 0, "R7 wrap down");
    move(1, 1, "R4 x4 up step");

    @(negedge clk);
    cmp_val[0 +: CW] = 16'h0002;
    move(0, 1, "R12 old buffer still matches");
    move(0, 0, "R12 new value not yet loaded");

    set_z(1, "R10 index rising clear");
    move(1, 0, "R4 x4 up step");
    set_z(0, "R10 falling edge ignored");
    @(negedge clk);
    clr_edge_sel = 2'b10;
    set_z(1, "R10 rising edge ignored");
    set_z(0, "R10 falling clear");

    @(negedge clk);
    dir_mode = 2'b11;
    move(1, 1, "R4 reversed x4 down");
    move(0, 1, "R4 reversed x4 down");

    @(negedge clk);
    dir_mode = 2'b00;
    move(0, 0, "R5 B edge ignored");
    move(1, 0, "R5 A rise B low up");
    move(1, 1, "R5 B edge ignored");
    move(0, 1, "R5 A fall ignored");
    move(1, 1, "R5 A rise B high down");

    @(negedge clk);
    dir_mode = 2'b01;
    move(0, 1, "R6 A fall step");
    move(0, 0, "R6 B edge ignored");
    move(1, 0, "R6 A rise step");
    move(1, 1, "R6 B edge ignored");

    @(negedge clk);
    dir_mode  = 2'b10;
    clr_level = 3'b000;
    @(negedge clk);
    clr_src_sel = 1'b1;
    move(0, 1, "R11 step outside pattern");
    move(0, 0, "R11 pattern clear wins");
    move(1, 0, "R11 step after leaving pattern");
    @(negedge clk);
    clr_src_sel = 1'b0;

    en_off("R13 disable holds count");
    move(1, 1, "R13 step ignored while off");
    move(0, 1, "R13 step ignored while off");
    en_on(1'b1, "R2 hold keeps count");
    move(0, 0, "R3 re-arm after enable");
    move(1, 0, "R8 reloaded buffer match");

    wait_drain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule